// File: doc/BRIEF.md
# Single to half precision narrower

This block narrows a 32-bit single-precision floating-point word to a 16-bit half-precision word. It moves the sign bit across, rebiases the exponent, and rounds away the thirteen fraction bits that do not fit. Values too small for a normal half become half subnormals, and values too large saturate to infinity. NaN inputs are mapped by a small fixed set of rules so that a NaN never turns into an infinity.

The conversion is purely combinational. A single output register follows it, with a valid strobe travelling alongside the data. A caller presents a word with `valid_in` high and collects the half result one clock later on `dout`, qualified by `valid_out`. One word can be accepted on every cycle.

Top module: `f2h_narrow`

## Requirements
- R1: Output bit 15 equals input bit 31 for every input, including zeros, infinities and NaNs.
- R2: For a single exponent field e in 113..142, the rounded fraction is the 23-bit fraction plus 2^13 when fraction bit 12 is set. If this sum stays below 2^23, the output is exponent field e-112 in bits 14:10 and bits 22:13 of the sum in bits 9:0. For example, 0x477FE000 gives 0x7BFF and 0x3F801000 gives 0x3C01.
- R3: If the rounded fraction of R2 reaches 2^23, the output exponent field is e-111 and the output fraction is zero. At e=142 this gives 0x7C00.
- R4: For e of 112 or less, the rounded fraction is ORed with 2^23 and shifted right by (113-e)+13 places, and the low 10 bits form the output fraction, with exponent field 0. A total shift of 24 or more gives zero, so single zeros and single subnormals give a signed zero.
- R5: An exponent field in 143..254, or an input infinity (e=255 with zero fraction), gives magnitude 0x7C00.
- R6: An input whose bits 30:22 are all ones (a quiet NaN) gives magnitude 0x7E00.
- R7: A NaN input with fraction bit 22 clear gives magnitude 0x7C00 ORed with fraction bits 22:13. If those bits are all zero, the magnitude is 0x7C01 instead.
- R8: `valid_out` in each cycle equals `valid_in` from the previous cycle. `dout` changes only in a cycle after `valid_in` was high, and otherwise holds its value.
- R9: A synchronous active-high `rst` clears `valid_out` on the next clock edge, even while `valid_in` is high.
- R10: Every half code widened exactly to single precision and then narrowed returns unchanged, except half quiet NaNs (exponent 31, fraction bit 9 set), which return as 0x7E00 with their sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Marks `din` as a word to convert in this cycle |
| din | input | 32 | Single-precision input word |
| valid_out | output | 1 | Marks `dout` as a new result |
| dout | output | 16 | Half-precision result, registered |

## Verification
The hardest cases to reach from the ports are the narrow input bands where rounding carries into the exponent. These are the top of the normal range just below 65504 and the exponent-112 band, where the carry is absorbed by the OR with the hidden bit. Random words almost never land in these bands. The stimulus therefore widens every one of the 65536 half codes back to single precision and pushes each through the block. It also adds directed words with fraction bit 12 set next to an all-ones fraction, together with a random sweep biased toward exponents 100 to 150.

// File: rtl/f2h_pkg.sv
package f2h_pkg;

    localparam int SGL_W       = 32;
    localparam int SGL_EXP_W   = 8;
    localparam int SGL_FRAC_W  = 23;
    localparam int HLF_W       = 16;
    localparam int HLF_EXP_W   = 5;
    localparam int HLF_FRAC_W  = 10;

    localparam int DROP_W      = SGL_FRAC_W - HLF_FRAC_W;
    localparam int SGL_BIAS    = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int HLF_BIAS    = (1 << (HLF_EXP_W - 1)) - 1;
    localparam int REBIAS      = SGL_BIAS - HLF_BIAS;
    localparam int HLF_EXP_MAX = (1 << HLF_EXP_W) - 1;
    localparam int HUGE_EXP    = REBIAS + HLF_EXP_MAX;
    localparam int SIG_W       = SGL_FRAC_W + 1;
    localparam int MAG_W       = HLF_W - 1;

    typedef logic [MAG_W-1:0] hmag_t;

    typedef struct packed {
        logic                  sign;
        logic [SGL_EXP_W-1:0]  exp;
        logic [SGL_FRAC_W-1:0] frac;
    } sgl_t;

    typedef struct packed {
        logic  sign;
        hmag_t mag;
    } hlf_t;

    typedef struct packed {
        logic nan_quiet;
        logic nan_any;
        logic nan_lost;
        logic huge;
        logic tiny;
    } cls_t;

    typedef enum logic [2:0] {
        PICK_NORM,
        PICK_CARRY,
        PICK_PAYLOAD,
        PICK_NANFIX,
        PICK_INF,
        PICK_SUB,
        PICK_QNAN
    } pick_e;

    localparam hmag_t HLF_INF_MAG    = {{HLF_EXP_W{1'b1}}, {HLF_FRAC_W{1'b0}}};
    localparam hmag_t HLF_QNAN_MAG   = {{HLF_EXP_W{1'b1}}, 1'b1, {(HLF_FRAC_W-1){1'b0}}};
    localparam hmag_t HLF_NANFIX_MAG = {{HLF_EXP_W{1'b1}}, {(HLF_FRAC_W-1){1'b0}}, 1'b1};

    function automatic hmag_t nan_payload_mag(input logic [HLF_FRAC_W-1:0] top);
        return {{HLF_EXP_W{1'b1}}, top};
    endfunction

endpackage

// File: rtl/f2h_rshift.sv
module f2h_rshift #(
    parameter int W   = 24,
    parameter int SHW = 8
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    localparam int STG = $clog2(W);

    logic [W-1:0] stage [0:STG];
    logic         too_far;

    assign stage[0] = din;
    assign too_far  = (amt >= SHW'(W));

    generate
        for (genvar k = 0; k < STG; k++) begin : g_stage
            assign stage[k+1] = amt[k] ? (stage[k] >> (1 << k)) : stage[k];
        end
    endgenerate

    assign dout = too_far ? '0 : stage[STG];
endmodule

// File: rtl/f2h_classify.sv
module f2h_classify
    import f2h_pkg::*;
(
    input  sgl_t word,
    output cls_t cls
);
    logic exp_ones;
    logic frac_nz;
    logic top_nz;

    assign exp_ones = &word.exp;
    assign frac_nz  = |word.frac;
    assign top_nz   = |word.frac[SGL_FRAC_W-1 -: HLF_FRAC_W];

    always_comb begin
        cls           = '0;
        cls.nan_any   = exp_ones & frac_nz;
        cls.nan_quiet = exp_ones & word.frac[SGL_FRAC_W-1];
        cls.nan_lost  = exp_ones & frac_nz & ~top_nz;
        cls.huge      = ~(exp_ones & frac_nz) & (word.exp >= SGL_EXP_W'(HUGE_EXP));
        cls.tiny      = (word.exp <= SGL_EXP_W'(REBIAS));
    end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
    import f2h_pkg::*;
(
    input  sgl_t  word,
    output logic  carry,
    output hmag_t norm_mag,
    output hmag_t carry_mag,
    output hmag_t sub_mag
);
    logic [SIG_W-1:0]     round_inc;
    logic [SIG_W-1:0]     rnd_frac;
    logic [SGL_EXP_W-1:0] exp_reb;
    logic [HLF_EXP_W-1:0] exp_n;
    logic [SGL_EXP_W-1:0] sub_sh;
    logic [SIG_W-1:0]     sig;
    logic [SIG_W-1:0]     shifted;
    logic                 shift_unused;

    assign round_inc = {{(SGL_FRAC_W-DROP_W){1'b0}}, word.frac[DROP_W-1], {DROP_W{1'b0}}};
    assign rnd_frac  = {1'b0, word.frac} + round_inc;
    assign carry     = rnd_frac[SGL_FRAC_W];

    assign exp_reb   = word.exp - SGL_EXP_W'(REBIAS);
    assign exp_n     = exp_reb[HLF_EXP_W-1:0];

    assign norm_mag  = {exp_n, rnd_frac[SGL_FRAC_W-1:DROP_W]};
    assign carry_mag = {exp_n + HLF_EXP_W'(1), rnd_frac[SGL_FRAC_W-1:DROP_W]};

    assign sub_sh    = SGL_EXP_W'(REBIAS + 1) - word.exp;
    assign sig       = rnd_frac | {1'b1, {SGL_FRAC_W{1'b0}}};

    f2h_rshift #(
        .W   (SIG_W),
        .SHW (SGL_EXP_W)
    ) u_sub_shift (
        .din  (sig),
        .amt  (sub_sh),
        .dout (shifted)
    );

    assign sub_mag = {{HLF_EXP_W{1'b0}}, shifted[DROP_W+HLF_FRAC_W-1:DROP_W]};

    assign shift_unused = ^{shifted[SIG_W-1], shifted[DROP_W-1:0],
                            exp_reb[SGL_EXP_W-1:HLF_EXP_W]};
endmodule

// File: rtl/f2h_select.sv
module f2h_select
    import f2h_pkg::*;
(
    input  logic                  sign,
    input  logic [HLF_FRAC_W-1:0] payload,
    input  cls_t                  cls,
    input  logic                  carry,
    input  hmag_t                 norm_mag,
    input  hmag_t                 carry_mag,
    input  hmag_t                 sub_mag,
    output hlf_t                  result
);
    pick_e pick;
    hmag_t mag;

    // later assignments outrank earlier ones
    always_comb begin
        pick = PICK_NORM;
        if (carry)         pick = PICK_CARRY;
        if (cls.nan_any)   pick = PICK_PAYLOAD;
        if (cls.nan_lost)  pick = PICK_NANFIX;
        if (cls.huge)      pick = PICK_INF;
        if (cls.tiny)      pick = PICK_SUB;
        if (cls.nan_quiet) pick = PICK_QNAN;
    end

    always_comb begin
        unique case (pick)
            PICK_NORM:    mag = norm_mag;
            PICK_CARRY:   mag = carry_mag;
            PICK_PAYLOAD: mag = nan_payload_mag(payload);
            PICK_NANFIX:  mag = HLF_NANFIX_MAG;
            PICK_INF:     mag = HLF_INF_MAG;
            PICK_SUB:     mag = sub_mag;
            PICK_QNAN:    mag = HLF_QNAN_MAG;
            default:      mag = norm_mag;
        endcase
    end

    assign result = '{sign: sign, mag: mag};
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
    import f2h_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_in,
    input  logic [SGL_W-1:0] din,
    output logic             valid_out,
    output logic [HLF_W-1:0] dout
);
    sgl_t  word;
    cls_t  cls;
    logic  carry;
    hmag_t norm_mag;
    hmag_t carry_mag;
    hmag_t sub_mag;
    hlf_t  result;

    assign word = sgl_t'(din);

    f2h_classify u_classify (
        .word (word),
        .cls  (cls)
    );

    f2h_round u_round (
        .word      (word),
        .carry     (carry),
        .norm_mag  (norm_mag),
        .carry_mag (carry_mag),
        .sub_mag   (sub_mag)
    );

    f2h_select u_select (
        .sign      (word.sign),
        .payload   (word.frac[SGL_FRAC_W-1 -: HLF_FRAC_W]),
        .cls       (cls),
        .carry     (carry),
        .norm_mag  (norm_mag),
        .carry_mag (carry_mag),
        .sub_mag   (sub_mag),
        .result    (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            dout      <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) dout <= result;
        end
    end

    assert_valid_lat_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (valid_out == $past(valid_in)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(valid_in)) |-> $stable(dout));

    assert_sign_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in)) |-> (dout[HLF_W-1] == $past(din[SGL_W-1])));

    assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && ($past(din[SGL_W-2:SGL_FRAC_W]) == '0))
        |-> (dout[HLF_W-2:0] == '0));

    assert_huge_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in)
         && ($past(din[SGL_W-2:SGL_FRAC_W]) >= SGL_EXP_W'(HUGE_EXP))
         && ($past(din[SGL_W-2:0]) <= {{SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}}))
        |-> (dout[HLF_W-2:0] == HLF_INF_MAG));

    assert_nan_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(valid_in) && (&$past(din[SGL_W-2:SGL_FRAC_W]))
         && (|$past(din[SGL_FRAC_W-1:0])))
        |-> ((&dout[HLF_W-2:HLF_FRAC_W]) && (|dout[HLF_FRAC_W-1:0])));
endmodule

// File: tb/f2h_narrow_tb.sv
module f2h_narrow_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_in = 1'b0;
    logic [31:0] din = '0;
    logic        valid_out;
    logic [15:0] dout;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [15:0] q_exp [$];
    string       q_tag [$];
    logic [15:0] last_exp = '0;

    always #5 clk = ~clk;

    f2h_narrow dut_i (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .din       (din),
        .valid_out (valid_out),
        .dout      (dout)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model written from the requirements
    function automatic logic [15:0] model(input logic [31:0] w);
        int          e;
        logic [22:0] f;
        logic [23:0] fr;
        logic [23:0] t;
        int          sh;
        logic [15:0] r;
        e = int'(w[30:23]);
        f = w[22:0];
        if ((w & 32'h7FC0_0000) == 32'h7FC0_0000) r = 16'h7E00;                 // R6
        else if (e == 255 && f != 0)
            r = (f[22:13] == 0) ? 16'h7C01 : (16'h7C00 | {6'd0, f[22:13]});     // R7
        else if (e >= 143) r = 16'h7C00;                                        // R5
        else begin
            fr = {1'b0, f} + (f[12] ? 24'h2000 : 24'h0);
            if (e <= 112) begin                                                 // R4
                sh = 113 - e + 13;
                t  = fr | 24'h80_0000;
                r  = (sh >= 24) ? 16'h0 : 16'(t >> sh);
            end else if (fr[23]) r = 16'((e - 111) << 10);                      // R3
            else r = 16'((e - 112) << 10) | {6'd0, fr[22:13]};                  // R2
        end
        r[15] = w[31];                                                          // R1
        return r;
    endfunction

    function automatic logic [31:0] widen(input logic [15:0] h);
        logic [4:0]  he;
        logic [9:0]  hm;
        logic [31:0] w;
        int          p;
        he = h[14:10];
        hm = h[9:0];
        w  = '0;
        w[31] = h[15];
        if (he == 5'd31) begin
            w[30:23] = 8'hFF;
            w[22:13] = hm;
        end else if (he == 0) begin
            if (hm != 0) begin
                p = 0;
                for (int i = 0; i < 10; i++) if (hm[i]) p = i;
                w[30:23] = 8'(103 + p);
                w[22:0]  = 23'({13'd0, hm} << (23 - p));
            end
        end else begin
            w[30:23] = 8'(int'(he) + 112);
            w[22:13] = hm;
        end
        return w;
    endfunction

    task automatic send(input logic [31:0] w, input logic [15:0] e, input string tag);
        @(negedge clk);
        valid_in = 1'b1;
        din      = w;
        q_exp.push_back(e);
        q_tag.push_back(tag);
        last_exp = e;
    endtask

    task automatic sendm(input logic [31:0] w, input string tag);
        send(w, model(w), tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_in = 1'b0;
            din      = 32'hDEAD_BEEF;
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (valid_out) begin
                if (q_exp.size() == 0) begin
                    check(1'b0, "R8 unexpected valid_out", 32'(valid_out), 32'h0);
                end else begin
                    logic [15:0] e;
                    string       t;
                    e = q_exp.pop_front();
                    t = q_tag.pop_front();
                    check(dout === e, t, 32'(dout), 32'(e));
                end
            end
        end
    end

    initial begin
        #1_500_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] w;
        seed = 32'h1234_5678;

        repeat (3) @(posedge clk);
        #2;
        check(valid_out === 1'b0, "R9 reset state", 32'(valid_out), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // directed boundaries
        send(32'h477F_E000, 16'h7BFF, "R2 largest finite");
        send(32'h477F_EFFF, 16'h7BFF, "R2 just below carry");
        send(32'h477F_F000, 16'h7C00, "R3 carry to infinity");
        send(32'h3F80_0000, 16'h3C00, "R2 one");
        send(32'h3F80_1000, 16'h3C01, "R2 round up");
        send(32'h3F80_0FFF, 16'h3C00, "R2 round down");
        send(32'h3FFF_F000, 16'h4000, "R3 carry into exponent");
        send(32'h3880_0000, 16'h0400, "R2 smallest normal");
        send(32'h3800_0000, 16'h0200, "R4 exponent 112");
        send(32'h387F_F000, 16'h0200, "R4 carry merged with hidden bit");
        send(32'h3380_0000, 16'h0001, "R4 smallest subnormal");
        send(32'h3300_0000, 16'h0000, "R4 shift past width");
        send(32'h0000_0001, 16'h0000, "R4 single subnormal");
        send(32'h8000_0000, 16'h8000, "R1 negative zero");
        send(32'h4780_0000, 16'h7C00, "R5 exponent 143");
        send(32'h7F00_0000, 16'h7C00, "R5 huge finite");
        send(32'h7F80_0000, 16'h7C00, "R5 infinity");
        send(32'hFF80_0000, 16'hFC00, "R1 R5 negative infinity");
        send(32'h7FC0_0000, 16'h7E00, "R6 quiet nan");
        send(32'hFFC1_2345, 16'hFE00, "R6 negative quiet nan");
        send(32'h7F80_4000, 16'h7C02, "R7 payload kept");
        send(32'h7F80_0001, 16'h7C01, "R7 payload lost");
        send(32'hFF80_0FFF, 16'hFC01, "R7 negative payload lost");

        // hold while idle
        idle(4);
        #2;
        check(dout === last_exp, "R8 hold while idle", 32'(dout), 32'(last_exp));
        check(valid_out === 1'b0, "R8 no valid when idle", 32'(valid_out), 32'h0);

        // reset while valid_in high
        @(negedge clk);
        rst = 1'b1;
        valid_in = 1'b1;
        din = 32'h3F80_0000;
        @(posedge clk);
        #2;
        check(valid_out === 1'b0, "R9 reset beats valid_in", 32'(valid_out), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        valid_in = 1'b0;
        idle(2);

        // every half code up and back down
        for (int c = 0; c < 65536; c++) begin
            logic [15:0] h;
            h = 16'(c);
            if (h[14:10] == 5'd31 && h[9]) send(widen(h), {h[15], 15'h7E00}, "R10 round trip");
            else send(widen(h), h, "R10 round trip");
        end

        // random words, half of them biased into the interesting exponents
        for (int i = 0; i < 20000; i++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            w = seed;
            if (i[0]) w[30:23] = 8'(100 + (seed[7:0] % 51));
            sendm(w, "R2 R3 R4 random");
            if ((i % 997) == 0) idle(1);
        end

        idle(5);
        check(q_exp.size() == 0, "R8 all results delivered", 32'(q_exp.size()), 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule